// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a 10-bit successive-approximation converter. It divides the system clock into a slower conversion clock. It decides when a conversion begins: on a software start, on an external trigger edge, or straight after the previous completion. It strobes the sample-and-hold at the right half-cycle. It presents one trial code per conversion clock to the comparator and resolves one result bit per clock, most significant bit first. At the end it writes the result, raises a sticky completion flag and drops the start bit.

The sequence has two lengths. A short one is 13 conversion clocks with the sample taken 1.5 clocks in. A long one is 25 clocks with the sample taken 13.5 clocks in. The long sequence is used for the first conversion after enabling. It is also used for every conversion when differential mode is combined with an external trigger. An external trigger realigns the divider, so the delay from trigger to sample is fixed.

Top module: `adc_conv_seq`

## Requirements
- R1: While `en_i` is low, `adc_clk_o` stays low. When enabled, its period is 2^(sel+1) system cycles for `div_sel_i` = sel in 0..6. The value 7 gives 128, the same as 6.
- R2: A pulse on `start_set_i` while enabled sets `start_o`. The conversion begins on the first later rising edge of `adc_clk_o`. A pulse while disabled is ignored.
- R3: A short conversion ends on the 14th rising conversion-clock edge, counting the starting edge as the first, which is 13 conversion clocks.
- R4: `sample_o` pulses for one system cycle right after a falling conversion-clock edge. This is 1.5 clocks after the start of a short conversion (after the 2nd rising edge) and 13.5 clocks after the start of a long conversion (after the 14th). The first conversion after enabling is long, and it ends on the 26th rising edge.
- R5: At completion, `result_we_o` pulses, `result_o` takes the new value and `done_flag_o` is set. In single mode `start_o` clears on the same edge.
- R6: Resolution is MSB first, one bit per conversion clock after sampling. `dac_code_o` carries the trial code, and it equals 512 right after the sample. `cmp_i`=1 means the input is at or above the trial code, so the trial bit is kept. The result equals the input code.
- R7: With `auto_trig_en_i`=1 and `trig_src_cc_i`=0, a rising edge on `trig_i` while idle starts a conversion and realigns the divider. `sample_o` is first seen high 2*D+3 system cycles after the first clock edge that samples `trig_i` high, and completion comes 13.5*D+3 cycles after it (D = divide ratio).
- R8: Differential mode together with an external trigger makes every conversion long: the sample comes 14*D+3 cycles and completion 25.5*D+3 cycles after the trigger.
- R9: In free-running mode, or when auto-trigger takes completion as its source, the next conversion starts on the completion edge itself. `start_o` stays high, and completions are 13 conversion clocks apart.
- R10: A pulse on `flag_clr_i` clears `done_flag_o`. A completion on the same edge wins.
- R11: Dropping `en_i` aborts a running conversion: no write, `result_o` unchanged, `start_o` cleared. The next conversion after re-enabling is long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| start_set_i | input | 1 | Software start request pulse |
| flag_clr_i | input | 1 | Completion flag clear pulse |
| auto_trig_en_i | input | 1 | Auto-trigger enable |
| trig_src_cc_i | input | 1 | Auto-trigger source is the block's own completion |
| trig_i | input | 1 | External trigger, asynchronous |
| free_run_i | input | 1 | Free-running mode |
| diff_mode_i | input | 1 | Differential input mode |
| div_sel_i | input | 3 | Divide-ratio select |
| cmp_i | input | 1 | Comparator output (input at or above trial code) |
| adc_clk_o | output | 1 | Divided conversion clock |
| sample_o | output | 1 | Sample-and-hold strobe |
| dac_code_o | output | 10 | Current trial code |
| result_o | output | 10 | Conversion result register |
| result_we_o | output | 1 | Result write strobe |
| done_flag_o | output | 1 | Sticky completion flag |
| start_o | output | 1 | Start bit state |

## Verification
The assertions check properties that hold on every cycle:
- the sample strobe follows a falling conversion-clock edge and loads the MSB trial code;
- a result write lands on a rising edge and sets the flag;
- the start bit clears on a single-mode completion and stays high in free-running mode;
- the result register moves only on a write;
- a flag clear takes effect;
- a disabled block issues no strobes.

Sequence lengths, sample points, trigger-to-sample latency, the long first and differential conversions, abort behaviour and the resolved values can only be shown by the bench's scenarios. These scenarios count conversion-clock edges and system cycles against a comparator model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_CONV} seq_state_e;

  // log2 of the divide ratio, saturated at cap
  function automatic int unsigned div_log2(input int unsigned sel, input int unsigned cap);
    int unsigned v;
    v = sel + 32'd1;
    return (v > cap) ? cap : v;
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler import adc_seq_pkg::*; #(
  parameter int unsigned MAX_LOG2 = 7,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             realign_i,
  output logic             adc_clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned CNT_W = MAX_LOG2;

  logic [CNT_W-1:0] cnt_q, lim, half;
  logic [CNT_W:0]   span;

  always_comb begin
    span = (CNT_W+1)'(1) << div_log2(32'(sel_i), MAX_LOG2);
    lim  = CNT_W'(span - 1'b1);
    half = lim >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (realign_i)      cnt_q <= half + 1'b1; // start of low phase
    else if (cnt_q == lim)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign rise_o    = en_i & ~realign_i & (cnt_q == lim);
  assign fall_o    = en_i & ~realign_i & (cnt_q == half);
  assign adc_clk_o = en_i & (cnt_q <= half);
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], trig_i};
  end

  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sar_q, bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
      bit_q <= '0;
    end else if (abort_i) begin
      bit_q <= '0;
    end else if (load_i) begin
      sar_q <= MSB_ONLY;
      bit_q <= MSB_ONLY;
    end else if (step_i && (bit_q != '0)) begin
      // keep or drop current trial bit, then try the next lower one
      sar_q <= (cmp_i ? sar_q : (sar_q & ~bit_q)) | (bit_q >> 1);
      bit_q <= bit_q >> 1;
    end
  end

  assign code_o = sar_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm import adc_seq_pkg::*; #(
  parameter int unsigned CYC_W     = 5,
  parameter int unsigned NORM_CYC  = 13,
  parameter int unsigned LONG_CYC  = 25,
  parameter int unsigned NORM_SAMP = 2,
  parameter int unsigned LONG_SAMP = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_set_i,
  input  logic auto_en_i,
  input  logic src_cc_i,
  input  logic ext_evt_i,
  input  logic free_run_i,
  input  logic diff_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic start_o,
  output logic realign_o,
  output logic sample_evt_o,
  output logic step_o,
  output logic done_evt_o
);
  seq_state_e       st_q;
  logic [CYC_W-1:0] cyc_q, last_cyc, samp_cyc;
  logic             long_q, first_q, start_q;
  logic             busy, restart, long_now, begin_conv;

  assign busy       = (st_q == SEQ_CONV);
  assign restart    = free_run_i | (auto_en_i & src_cc_i);
  assign long_now   = first_q | (diff_i & auto_en_i & ~src_cc_i);
  assign last_cyc   = long_q ? CYC_W'(LONG_CYC)  : CYC_W'(NORM_CYC);
  assign samp_cyc   = long_q ? CYC_W'(LONG_SAMP) : CYC_W'(NORM_SAMP);

  assign realign_o    = en_i & auto_en_i & ~src_cc_i & ext_evt_i & ~busy;
  assign done_evt_o   = busy & rise_i & (cyc_q == last_cyc);
  assign sample_evt_o = busy & fall_i & (cyc_q == samp_cyc);
  assign step_o       = busy & rise_i;
  assign begin_conv   = ~busy & rise_i & start_q;
  assign start_o      = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SEQ_IDLE;
      cyc_q   <= '0;
      long_q  <= 1'b0;
      first_q <= 1'b1;
      start_q <= 1'b0;
    end else if (!en_i) begin
      st_q    <= SEQ_IDLE;
      cyc_q   <= '0;
      first_q <= 1'b1;
      start_q <= 1'b0;
    end else begin
      if (done_evt_o) begin
        start_q <= restart;
        if (restart) begin
          cyc_q  <= CYC_W'(1);
          long_q <= long_now;
        end else begin
          st_q <= SEQ_IDLE;
        end
      end else if (busy && rise_i) begin
        cyc_q <= cyc_q + 1'b1;
      end else if (begin_conv) begin
        st_q    <= SEQ_CONV;
        cyc_q   <= CYC_W'(1);
        long_q  <= long_now;
        first_q <= 1'b0;
      end
      if (!done_evt_o && (start_set_i || realign_o)) start_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq import adc_seq_pkg::*; #(
  parameter int unsigned RES_W        = 10,
  parameter int unsigned SEL_W        = 3,
  parameter int unsigned MAX_DIV_LOG2 = 7,
  parameter int unsigned NORM_CYC     = 13,
  parameter int unsigned LONG_CYC     = 25,
  parameter int unsigned NORM_SAMP    = 2,
  parameter int unsigned LONG_SAMP    = 14,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_set_i,
  input  logic             flag_clr_i,
  input  logic             auto_trig_en_i,
  input  logic             trig_src_cc_i,
  input  logic             trig_i,
  input  logic             free_run_i,
  input  logic             diff_mode_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             cmp_i,
  output logic             adc_clk_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_we_o,
  output logic             done_flag_o,
  output logic             start_o
);
  localparam int unsigned CYC_W = $clog2(LONG_CYC + 1);

  logic rise, fall, realign, ext_evt;
  logic sample_evt, step, done_evt;
  logic [RES_W-1:0] code;

  adc_prescaler #(.MAX_LOG2(MAX_DIV_LOG2), .SEL_W(SEL_W)) u_presc (
    .clk_i, .rst_ni, .en_i, .sel_i(div_sel_i), .realign_i(realign),
    .adc_clk_o, .rise_o(rise), .fall_o(fall)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .trig_i, .edge_o(ext_evt)
  );

  adc_seq_fsm #(
    .CYC_W(CYC_W), .NORM_CYC(NORM_CYC), .LONG_CYC(LONG_CYC),
    .NORM_SAMP(NORM_SAMP), .LONG_SAMP(LONG_SAMP)
  ) u_fsm (
    .clk_i, .rst_ni, .en_i, .start_set_i,
    .auto_en_i(auto_trig_en_i), .src_cc_i(trig_src_cc_i), .ext_evt_i(ext_evt),
    .free_run_i, .diff_i(diff_mode_i), .rise_i(rise), .fall_i(fall),
    .start_o, .realign_o(realign), .sample_evt_o(sample_evt),
    .step_o(step), .done_evt_o(done_evt)
  );

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk_i, .rst_ni, .abort_i(~en_i), .load_i(sample_evt), .step_i(step),
    .cmp_i, .code_o(code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      done_flag_o <= 1'b0;
      result_we_o <= 1'b0;
      sample_o    <= 1'b0;
    end else begin
      result_we_o <= done_evt;
      sample_o    <= sample_evt;
      if (done_evt) result_o <= code;
      if (done_evt)        done_flag_o <= 1'b1;
      else if (flag_clr_i) done_flag_o <= 1'b0;
    end
  end

  assign dac_code_o = code;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             flag_clr_i,
  input logic             free_run_i,
  input logic             auto_trig_en_i,
  input logic             trig_src_cc_i,
  input logic             adc_clk_o,
  input logic             sample_o,
  input logic             result_we_o,
  input logic             done_flag_o,
  input logic             start_o,
  input logic [RES_W-1:0] result_o,
  input logic [RES_W-1:0] dac_code_o
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  p_quiet_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sample_o && !result_we_o && !start_o));

  p_we_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_we_o && en_i) |-> (adc_clk_o && !$past(adc_clk_o)));

  p_sample_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (!adc_clk_o && $past(adc_clk_o)));

  p_flag_on_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_we_o |-> done_flag_o);

  p_start_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_we_o && !$past(free_run_i) && !($past(auto_trig_en_i) && $past(trig_src_cc_i)))
      |-> !start_o);

  p_msb_trial_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (dac_code_o == MSB_ONLY));

  p_free_run_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_we_o && $past(free_run_i) && $past(en_i)) |-> start_o);

  p_flag_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_clr_i) && !result_we_o) |-> !done_flag_o);

  p_result_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_we_o |-> $stable(result_o));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .flag_clr_i(flag_clr_i),
  .free_run_i(free_run_i), .auto_trig_en_i(auto_trig_en_i),
  .trig_src_cc_i(trig_src_cc_i), .adc_clk_o(adc_clk_o), .sample_o(sample_o),
  .result_we_o(result_we_o), .done_flag_o(done_flag_o), .start_o(start_o),
  .result_o(result_o), .dac_code_o(dac_code_o)
);

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni, en_i, start_set_i, flag_clr_i, auto_trig_en_i, trig_src_cc_i;
  logic       trig_i, free_run_i, diff_mode_i, cmp_i;
  logic [2:0] div_sel_i;
  logic       adc_clk_o, sample_o, result_we_o, done_flag_o, start_o;
  logic [9:0] dac_code_o, result_o;
  logic [9:0] vin;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign cmp_i = (dac_code_o <= vin);

  adc_conv_seq dut_i (
    .clk_i, .rst_ni, .en_i, .start_set_i, .flag_clr_i, .auto_trig_en_i,
    .trig_src_cc_i, .trig_i, .free_run_i, .diff_mode_i, .div_sel_i, .cmp_i,
    .adc_clk_o, .sample_o, .dac_code_o, .result_o, .result_we_o,
    .done_flag_o, .start_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input int sel);
    return 2 << ((sel > 6) ? 6 : sel);
  endfunction

  task automatic wait_rise();
    logic p;
    p = adc_clk_o;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i);
      if (adc_clk_o && !p) break;
      p = adc_clk_o;
    end
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
    chk(!done_flag_o, "R10 flag clear", int'(done_flag_o), 0);
  endtask

  task automatic sw_conv(input logic [9:0] v, input bit lng, input string tag);
    int rises, s_at, w_at, exp_n, exp_s;
    logic p;
    vin = v;
    wait_rise();
    p = adc_clk_o;
    start_set_i = 1'b1;
    rises = 0; s_at = -1; w_at = -1;
    for (int i = 0; i < 20000 && w_at < 0; i++) begin
      @(negedge clk_i);
      start_set_i = 1'b0;
      if (adc_clk_o && !p) rises++;
      p = adc_clk_o;
      if (sample_o && s_at < 0) s_at = rises;
      if (result_we_o) w_at = rises;
    end
    exp_n = lng ? 26 : 14;
    exp_s = lng ? 14 : 2;
    chk(s_at == exp_s, {tag, " R4 sample edge"}, s_at, exp_s);
    chk(w_at == exp_n, {tag, " R3 completion edge"}, w_at, exp_n);
    chk(result_o == v, {tag, " R6 result"}, int'(result_o), int'(v));
    chk(done_flag_o, {tag, " R5 flag"}, int'(done_flag_o), 1);
    chk(!start_o, {tag, " R5 start cleared"}, int'(start_o), 0);
    clr_flag();
  endtask

  // divider assumed at D=4
  task automatic trig_conv(input logic [9:0] v, input bit lng, input string tag);
    int s_at, w_at, exp_s, exp_w;
    vin = v;
    trig_i = 1'b1;
    s_at = -1; w_at = -1;
    for (int c = 1; c < 400 && w_at < 0; c++) begin
      @(negedge clk_i);
      if (sample_o && s_at < 0) s_at = c;
      if (result_we_o) w_at = c;
    end
    trig_i = 1'b0;
    exp_s = lng ? 14*4 + 3 : 2*4 + 3;
    exp_w = lng ? (51*4)/2 + 3 : (27*4)/2 + 3;
    chk(s_at == exp_s, {tag, " trigger-to-sample"}, s_at, exp_s);
    chk(w_at == exp_w, {tag, " trigger-to-completion"}, w_at, exp_w);
    chk(result_o == v, {tag, " R6 result"}, int'(result_o), int'(v));
    repeat (4) @(negedge clk_i);
    clr_flag();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0] prev, v;
    int n, w1, w2;
    logic p, seen_we;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; en_i = 1'b0; start_set_i = 1'b0; flag_clr_i = 1'b0;
    auto_trig_en_i = 1'b0; trig_src_cc_i = 1'b0; trig_i = 1'b0;
    free_run_i = 1'b0; diff_mode_i = 1'b0; div_sel_i = 3'd0; vin = '0;
    repeat (3) @(negedge clk_i);
    chk(!adc_clk_o && !sample_o && !result_we_o && !start_o && !done_flag_o && result_o == 0,
        "R1 reset state", int'(result_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: start ignored while disabled
    start_set_i = 1'b1;
    @(negedge clk_i);
    start_set_i = 1'b0;
    @(negedge clk_i);
    chk(!start_o, "R2 start ignored when disabled", int'(start_o), 0);
    chk(!adc_clk_o, "R1 clock idle when disabled", int'(adc_clk_o), 0);

    // R1: divider sweep
    en_i = 1'b1;
    for (int s = 0; s < 8; s++) begin
      div_sel_i = 3'(s);
      wait_rise();
      wait_rise();
      n = 0;
      p = adc_clk_o;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk_i);
        n++;
        if (adc_clk_o && !p) break;
        p = adc_clk_o;
      end
      chk(n == div_of(s), "R1 divide ratio", n, div_of(s));
    end

    // first conversion after enable is long
    div_sel_i = 3'd0;
    sw_conv(10'($urandom_range(1023, 0)), 1'b1, "first");
    sw_conv(10'd0, 1'b0, "zero");
    sw_conv(10'd1023, 1'b0, "full");
    div_sel_i = 3'd2;
    sw_conv(10'd512, 1'b0, "mid");
    for (int k = 0; k < 6; k++) begin
      div_sel_i = 3'($urandom_range(2, 0));
      sw_conv(10'($urandom_range(1023, 0)), 1'b0, "random");
    end

    // R11: abort
    prev = result_o;
    vin = 10'($urandom_range(1023, 0));
    wait_rise();
    start_set_i = 1'b1;
    @(negedge clk_i);
    start_set_i = 1'b0;
    repeat (20) @(negedge clk_i);
    en_i = 1'b0;
    seen_we = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (result_we_o) seen_we = 1'b1;
    end
    chk(!seen_we, "R11 no write after abort", int'(seen_we), 0);
    chk(result_o == prev, "R11 result unchanged", int'(result_o), int'(prev));
    chk(!start_o, "R11 start cleared", int'(start_o), 0);
    en_i = 1'b1;
    sw_conv(10'($urandom_range(1023, 0)), 1'b1, "R11 re-enable long");

    // R7: external trigger
    div_sel_i = 3'd1;
    auto_trig_en_i = 1'b1;
    repeat (5) @(negedge clk_i);
    trig_conv(10'($urandom_range(1023, 0)), 1'b0, "R7");

    // R8: differential with external trigger, every conversion long
    diff_mode_i = 1'b1;
    trig_conv(10'($urandom_range(1023, 0)), 1'b1, "R8 first");
    trig_conv(10'($urandom_range(1023, 0)), 1'b1, "R8 second");
    diff_mode_i = 1'b0;
    auto_trig_en_i = 1'b0;

    // R9: free-running
    free_run_i = 1'b1;
    v = 10'($urandom_range(1023, 0));
    vin = v;
    wait_rise();
    start_set_i = 1'b1;
    w1 = -1; w2 = -1;
    for (int c = 1; c < 2000 && w2 < 0; c++) begin
      @(negedge clk_i);
      start_set_i = 1'b0;
      if (result_we_o) begin
        if (w1 < 0) begin
          w1 = c;
          chk(start_o, "R9 start stays high", int'(start_o), 1);
        end else begin
          w2 = c;
        end
      end
    end
    chk(w2 - w1 == 13*4, "R9 back-to-back spacing", w2 - w1, 13*4);
    chk(result_o == v, "R9 result", int'(result_o), int'(v));
    en_i = 1'b0;
    free_run_i = 1'b0;
    repeat (3) @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule